// File: doc/BRIEF.md
# Clock Output Gating and Stop Control

This block sits between the clock sources of a system clock generator and the output pads. For every clock output (CPU pair, five stoppable PCI clocks, a free-running PCI clock, thirteen SDRAM copies, two reference clocks, an interrupt-controller clock, and the 48 MHz and 24 MHz clocks) it decides whether the pad shows the running source, is parked low, or floats. Source clocks arrive as levels sampled by the block's fast control clock; clock synthesis and modulation live elsewhere.

Each output has an enable register that may only change while its source is low, so a gated clock never shows a clipped high phase. A stop request for the five PCI clocks is sampled on rising edges of the free-running PCI source and applied one PCI cycle later, parking the stopped clocks low. A board-level output-enable pin and a register three-state code both float every pad; the pad drive enable is one register shared by all outputs and overrides any per-output setting. A strap input says whether the shared pin is the stop request or the REF0 clock.

Top module: `clk_out_gate`

## Requirements
- R1: While reset is applied every gated clock output is low and `pad_drive` is 0.
- R2: With its active bit at 1 an output follows its source; at 0 it is held low. A change of the active bit takes effect only at the next rising edge of the source, so the current high phase is never shortened and no partial pulse appears.
- R3: SDRAM outputs are enabled in groups: `sdr_act[g]` (g = 0..2) controls `sdr_clk[4g+3:4g]`, and `sdr_act[3]` controls `sdr_clk[12]` alone.
- R4: `stop_req_n` is sampled at each rising edge of `pci_src`; a low value parks `pci_clk[4:0]` low starting with the following PCI cycle (the cycle whose rising edge did the sampling still pulses), and a high value resumes them with the same one-cycle delay.
- R5: `pcif_clk` follows `pci_src` (gated only by `pcif_act`) regardless of `stop_req_n`.
- R6: `oe_pin` low makes `pad_drive` 0 one control-clock cycle later; high allows drive.
- R7: `tri_sel` = 2'b11 makes `pad_drive` 0 one cycle later; codes 2'b00, 2'b01 (reserved) and 2'b10 leave the pads driven. Three-state wins over every active bit and the stop state.
- R8: With `strap_ref_mode` = 1 the stop input is ignored (PCI clocks run) and `ref_clk[0]` follows `ref_act[0]`; with `strap_ref_mode` = 0 `ref_clk[0]` is held low.
- R9: `apic_clk` follows `ref_src`, `usb_clk` follows `usb_src` and `sio_clk` follows `sio_src`, each gated by its own active bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock that samples all source levels |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src | input | 1 | CPU source clock level |
| pci_src | input | 1 | PCI source clock level |
| sdr_src | input | 1 | SDRAM buffered source level |
| ref_src | input | 1 | Crystal reference level |
| usb_src | input | 1 | 48 MHz source level |
| sio_src | input | 1 | 24 MHz source level |
| strap_ref_mode | input | 1 | 1: shared pin is REF0; 0: it is the stop request |
| stop_req_n | input | 1 | PCI stop request, low stops |
| oe_pin | input | 1 | Board output enable, low floats all pads |
| tri_sel | input | 2 | Three-state code, 2'b11 floats all pads |
| cpu_act | input | 2 | Per-output active bits, CPU |
| pci_act | input | 5 | Per-output active bits, stoppable PCI |
| pcif_act | input | 1 | Active bit, free-running PCI |
| sdr_act | input | 4 | SDRAM group active bits |
| ref_act | input | 2 | Reference output active bits |
| apic_act | input | 1 | Interrupt-controller clock active bit |
| usb_act | input | 1 | 48 MHz active bit |
| sio_act | input | 1 | 24 MHz active bit |
| cpu_clk | output | 2 | Gated CPU clocks |
| pci_clk | output | 5 | Gated stoppable PCI clocks |
| pcif_clk | output | 1 | Gated free-running PCI clock |
| sdr_clk | output | 13 | Gated SDRAM clocks |
| ref_clk | output | 2 | Gated reference clocks |
| apic_clk | output | 1 | Gated interrupt-controller clock |
| usb_clk | output | 1 | Gated 48 MHz clock |
| sio_clk | output | 1 | Gated 24 MHz clock |
| pad_drive | output | 1 | Drive enable for every pad, 0 means high impedance |

## Verification
The hardest case to reach is the exact PCI cycle in which a stop or resume takes hold, because the request is sampled on a source edge rather than on the control clock. The bench generates each source with its own half period, locates the first sample after a PCI rising edge, changes the stop request right there so the next rising edge samples it, and then counts high samples in three consecutive PCI periods. The same phase-locking is used to flip a CPU active bit in mid high phase and show that the pulse in flight is neither cut nor started late.

// File: rtl/clk_out_gate_pkg.sv
package clk_out_gate_pkg;
  typedef enum logic [1:0] {
    TRI_RUN_A = 2'b00,
    TRI_RSVD  = 2'b01,
    TRI_RUN_B = 2'b10,
    TRI_FLOAT = 2'b11
  } tri_code_e;
endpackage

// File: rtl/clkgate_cell.sv
module clkgate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic want,
  output logic gclk
);
  logic en_q;
  logic en_d;

  // enable may only be reloaded while the source level is low
  always_comb begin
    en_d = en_q;
    if (!src) en_d = want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign gclk = src & en_q;

  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != $past(en_q)) |-> !$past(src));
  p_no_runt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gclk) |-> $rose(src));
endmodule

// File: rtl/pci_stop_sync.sv
module pci_stop_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic stop_n,
  output logic run_q
);
  logic prev_q;
  logic run_d;

  always_comb begin
    run_d = run_q;
    if (src && !prev_q) run_d = stop_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= 1'b1;
    end else begin
      prev_q <= src;
      run_q  <= run_d;
    end
  end

  p_stop_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != $past(run_q)) |-> ($past(src) && !$past(prev_q)));
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate #(
  parameter int N_CPU     = 2,
  parameter int N_PCI     = 5,
  parameter int N_SDR_GRP = 3,
  parameter int SDR_GRP_W = 4,
  parameter int N_REF     = 2,
  localparam int N_SDR    = N_SDR_GRP * SDR_GRP_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_src,
  input  logic               pci_src,
  input  logic               sdr_src,
  input  logic               ref_src,
  input  logic               usb_src,
  input  logic               sio_src,
  input  logic               strap_ref_mode,
  input  logic               stop_req_n,
  input  logic               oe_pin,
  input  logic [1:0]         tri_sel,
  input  logic [N_CPU-1:0]   cpu_act,
  input  logic [N_PCI-1:0]   pci_act,
  input  logic               pcif_act,
  input  logic [N_SDR_GRP:0] sdr_act,
  input  logic [N_REF-1:0]   ref_act,
  input  logic               apic_act,
  input  logic               usb_act,
  input  logic               sio_act,
  output logic [N_CPU-1:0]   cpu_clk,
  output logic [N_PCI-1:0]   pci_clk,
  output logic               pcif_clk,
  output logic [N_SDR-1:0]   sdr_clk,
  output logic [N_REF-1:0]   ref_clk,
  output logic               apic_clk,
  output logic               usb_clk,
  output logic               sio_clk,
  output logic               pad_drive
);
  import clk_out_gate_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // PCI stop path
  logic stop_run_q;
  logic pci_run;
  pci_stop_sync u_stop (
    .clk   (clk),
    .rst_n (rst_int_n),
    .src   (pci_src),
    .stop_n(stop_req_n),
    .run_q (stop_run_q)
  );
  assign pci_run = strap_ref_mode | stop_run_q;

  // pad drive: shared by every output, three-state dominates
  logic drive_d;
  logic drive_q;
  always_comb begin
    drive_d = oe_pin;
    if (tri_code_e'(tri_sel) == TRI_FLOAT) drive_d = 1'b0;
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) drive_q <= 1'b0;
    else            drive_q <= drive_d;
  end
  assign pad_drive = drive_q;

  p_oe_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !oe_pin |=> !pad_drive);
  p_tri_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tri_sel == 2'b11) |=> !pad_drive);

  // per-output gate cells
  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    clkgate_cell u_cell (.clk(clk), .rst_n(rst_int_n), .src(cpu_src),
                         .want(cpu_act[i]), .gclk(cpu_clk[i]));
  end

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    clkgate_cell u_cell (.clk(clk), .rst_n(rst_int_n), .src(pci_src),
                         .want(pci_act[i] & pci_run), .gclk(pci_clk[i]));
  end

  clkgate_cell u_pcif (.clk(clk), .rst_n(rst_int_n), .src(pci_src),
                       .want(pcif_act), .gclk(pcif_clk));

  for (genvar i = 0; i < N_SDR; i++) begin : g_sdr
    localparam int GRP = (i < N_SDR_GRP * SDR_GRP_W) ? (i / SDR_GRP_W) : N_SDR_GRP;
    clkgate_cell u_cell (.clk(clk), .rst_n(rst_int_n), .src(sdr_src),
                         .want(sdr_act[GRP]), .gclk(sdr_clk[i]));
  end

  for (genvar i = 0; i < N_REF; i++) begin : g_ref
    if (i == 0) begin : g_shared
      clkgate_cell u_cell (.clk(clk), .rst_n(rst_int_n), .src(ref_src),
                           .want(ref_act[i] & strap_ref_mode), .gclk(ref_clk[i]));
    end else begin : g_plain
      clkgate_cell u_cell (.clk(clk), .rst_n(rst_int_n), .src(ref_src),
                           .want(ref_act[i]), .gclk(ref_clk[i]));
    end
  end

  clkgate_cell u_apic (.clk(clk), .rst_n(rst_int_n), .src(ref_src),
                       .want(apic_act), .gclk(apic_clk));
  clkgate_cell u_usb  (.clk(clk), .rst_n(rst_int_n), .src(usb_src),
                       .want(usb_act), .gclk(usb_clk));
  clkgate_cell u_sio  (.clk(clk), .rst_n(rst_int_n), .src(sio_src),
                       .want(sio_act), .gclk(sio_clk));
endmodule

// File: tb/clk_out_gate_test.sv
`timescale 1ns/1ps
module clk_out_gate_test;
  localparam int NCPU = 2, NPCI = 5, NGRP = 3, GW = 4, NREF = 2;
  localparam int NSDR = NGRP * GW + 1;
  localparam int CH = 2, PH = 3, SH = 4, RH = 5, UH = 1, IH = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic cpu_src = 0, pci_src = 0, sdr_src = 0, ref_src = 0, usb_src = 0, sio_src = 0;
  int ccnt = 0, pcnt = 0, scnt = 0, rcnt = 0, ucnt = 0, icnt = 0;
  logic strap_ref_mode, stop_req_n, oe_pin;
  logic [1:0] tri_sel;
  logic [NCPU-1:0] cpu_act;
  logic [NPCI-1:0] pci_act;
  logic pcif_act, apic_act, usb_act, sio_act;
  logic [NGRP:0] sdr_act;
  logic [NREF-1:0] ref_act;
  logic [NCPU-1:0] cpu_clk;
  logic [NPCI-1:0] pci_clk;
  logic pcif_clk, apic_clk, usb_clk, sio_clk, pad_drive;
  logic [NSDR-1:0] sdr_clk;
  logic [NREF-1:0] ref_clk;

  clk_out_gate uut (.*);

  // source generators, all changing on the falling control edge
  always @(negedge clk) begin
    if (ccnt == CH-1) begin ccnt <= 0; cpu_src <= ~cpu_src; end else ccnt <= ccnt + 1;
    if (pcnt == PH-1) begin pcnt <= 0; pci_src <= ~pci_src; end else pcnt <= pcnt + 1;
    if (scnt == SH-1) begin scnt <= 0; sdr_src <= ~sdr_src; end else scnt <= scnt + 1;
    if (rcnt == RH-1) begin rcnt <= 0; ref_src <= ~ref_src; end else rcnt <= rcnt + 1;
    if (ucnt == UH-1) begin ucnt <= 0; usb_src <= ~usb_src; end else ucnt <= ucnt + 1;
    if (icnt == IH-1) begin icnt <= 0; sio_src <= ~sio_src; end else icnt <= icnt + 1;
  end

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [63:0] pack_out();
    return {pad_drive, sio_clk, usb_clk, apic_clk, ref_clk, sdr_clk, pcif_clk, pci_clk, cpu_clk};
  endfunction

  function automatic logic [63:0] pack_exp();
    logic [NSDR-1:0] s;
    logic run;
    for (int i = 0; i < NSDR; i++) begin
      int g = (i < NGRP*GW) ? i / GW : NGRP;
      s[i] = sdr_src & sdr_act[g];
    end
    run = strap_ref_mode | stop_req_n;
    return {oe_pin & (tri_sel != 2'b11),
            sio_src & sio_act, usb_src & usb_act, ref_src & apic_act,
            ref_src & ref_act[1], ref_src & ref_act[0] & strap_ref_mode,
            s, pci_src & pcif_act,
            {NPCI{pci_src & run}} & pci_act, {NCPU{cpu_src}} & cpu_act};
  endfunction

  // settle, then compare every output over many samples; one check
  task automatic check_steady(input string req);
    logic [63:0] bad_got, bad_exp;
    logic bad;
    bad = 0; bad_got = '0; bad_exp = '0;
    repeat (30) tick();
    for (int k = 0; k < 24; k++) begin
      if (!bad && pack_out() !== pack_exp()) begin
        bad = 1; bad_got = pack_out(); bad_exp = pack_exp();
      end
      tick();
    end
    if (bad) chk(req, bad_got, bad_exp);
    else     chk(req, 0, 0);
  endtask

  task automatic set_cfg(input logic [16:0] c);
    cpu_act = c[1:0]; pci_act = c[6:2]; pcif_act = c[7]; sdr_act = c[11:8];
    ref_act = c[13:12]; apic_act = c[14]; usb_act = c[15]; sio_act = c[16];
  endtask

  task automatic wait_pci_rise();
    do tick(); while (!(pci_src && pcnt == 0));
  endtask

  task automatic wait_cpu_rise();
    do tick(); while (!(cpu_src && ccnt == 0));
  endtask

  // counts high samples of pci_clk[0] and pcif_clk over one PCI period, starting at a rise sample
  task automatic count_period(output int hp, output int hf);
    hp = 0; hf = 0;
    for (int i = 0; i < 2*PH; i++) begin
      if (i > 0) tick();
      hp += pci_clk[0]; hf += pcif_clk;
    end
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hp, hf;
    rst_n = 0; strap_ref_mode = 1; stop_req_n = 1; oe_pin = 1; tri_sel = 2'b00;
    set_cfg('1);
    repeat (12) tick();
    chk("R1 reset outputs", pack_out(), 64'h0);
    rst_n = 1;

    // R2 R3 R9 R8: all on, all off, walking one over every active bit
    check_steady("R2 all active");
    set_cfg('0);
    check_steady("R2 all disabled");
    for (int b = 0; b < 17; b++) begin
      set_cfg(17'(1) << b);
      if (b >= 8 && b <= 11)       check_steady("R3 sdram group walk");
      else if (b >= 12 && b <= 13) check_steady("R8 ref walk");
      else if (b >= 14)            check_steady("R9 misc walk");
      else                         check_steady("R2 walk");
    end

    // R8/R4 strap and stop combinations in steady state
    set_cfg('1);
    for (int m = 0; m < 4; m++) begin
      strap_ref_mode = m[1]; stop_req_n = m[0];
      if (m[1]) check_steady("R8 strap ref mode");
      else      check_steady("R4 steady stop level");
    end
    strap_ref_mode = 1; stop_req_n = 1;

    // R6 R7 exhaustive pad drive
    for (int m = 0; m < 8; m++) begin
      oe_pin = m[2]; tri_sel = m[1:0];
      tick();
      if (!m[2]) chk("R6 oe low floats", pad_drive, 0);
      else       chk("R7 three-state code", pad_drive, (m[1:0] == 2'b11) ? 0 : 1);
    end
    oe_pin = 1; tri_sel = 2'b11; set_cfg('0);
    tick();
    chk("R7 float wins over disables", pad_drive, 0);
    tri_sel = 2'b00;
    set_cfg('1);
    repeat (30) tick();

    // R2: disable in mid high phase, current pulse not cut
    wait_cpu_rise();
    cpu_act = 2'b00;
    tick();
    chk("R2 pulse in flight kept", cpu_clk, 2'b11);
    repeat (2*CH) tick();
    wait_cpu_rise();
    chk("R2 disabled low", cpu_clk, 2'b00);
    cpu_act = 2'b11;
    tick();
    chk("R2 no partial pulse on enable", cpu_clk, 2'b00);
    wait_cpu_rise();
    chk("R2 enabled at next edge", cpu_clk, 2'b11);

    // R4 R5: stop latency with strap selecting the stop function
    strap_ref_mode = 0; stop_req_n = 1;
    repeat (30) tick();
    wait_pci_rise();
    stop_req_n = 0;
    count_period(hp, hf);
    chk("R4 before sampling edge", hp, PH);
    count_period(hp, hf);
    chk("R4 sampled cycle still runs", hp, PH);
    chk("R5 free clock in stop", hf, PH);
    count_period(hp, hf);
    chk("R4 stopped parks low", hp, 0);
    chk("R5 free clock runs", hf, PH);
    stop_req_n = 1;
    count_period(hp, hf);
    chk("R4 still stopped", hp, 0);
    count_period(hp, hf);
    chk("R4 resume delayed a cycle", hp, 0);
    count_period(hp, hf);
    chk("R4 resumed", hp, PH);

    // R8: strap ref mode ignores stop
    strap_ref_mode = 1; stop_req_n = 0;
    check_steady("R8 stop ignored");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule